// File: doc/BRIEF.md
# Small Multicycle Register-File Processor

This block is a compact processor made of a controller and a datapath. It holds a 16-bit program counter, a 16-bit instruction register and sixteen 16-bit general registers. One unified memory, 16 bits wide, holds both the program and the data. The memory sits outside the block and answers reads one cycle after the address appears.

Every instruction takes a fetch cycle, then a decode cycle, then its own execute cycle or cycles, and control then returns to fetch. The instruction set has seven operations: three moves to or from memory, a move of an immediate value, add, subtract, and a branch taken when a register is zero. Any other operation code stops the processor until the next reset.

Top module: `mc_proc`

## Requirements
- R1: While `rst` is high, `halted` is 0 and no memory write is issued. After `rst` is released, the first access is a read at address 0.
- R2: Each instruction begins with a fetch cycle, which is a read at the PC and increments the PC. A decode cycle follows with no memory access. Read and write are never active in the same cycle.
- R3: Operation code 0 (bits 15..12 of the instruction) reads memory at the 8-bit address in bits 7..0. This takes two execute cycles: a read cycle, then an idle cycle in which the register named by bits 11..8 captures the read data.
- R4: Operation code 1 writes the register named by bits 11..8 to memory at address bits 7..0, in one execute cycle.
- R5: Operation code 2 writes the register named by bits 7..4 to the memory address held in the register named by bits 11..8.
- R6: Operation code 3 writes bits 7..0, zero-extended, into the register named by bits 11..8.
- R7: Operation codes 4 and 5 set register rn (bits 11..8) to rn plus, or rn minus, register rm (bits 7..4). The result wraps modulo 2^16.
- R8: Operation code 6 with register rn equal to zero loads the PC with the incremented PC plus bits 7..0, sign-extended.
- R9: Operation code 6 with a nonzero register rn leaves the PC at the next instruction.
- R10: Operation codes 7 to 15 set `halted` one cycle after decode. It stays 1, with no memory access, until reset.
- R11: A loop that sums 1 to 10 and stores the total leaves 55 in memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid the cycle after the request |
| halted | output | 1 | Stopped on an undefined operation |

## Verification
The assertions assume the memory returns the word for the requested address exactly one cycle after `mem_re`. They also assume reset is held for at least one clock before a program runs. The bench memory is a synchronous array with that one-cycle latency, and each program is loaded while reset is high. The test programs keep every data address and every register-held address below 256, which is the size of the bench memory.

// File: rtl/mc_proc.sv
module mc_proc (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] mem_addr,
  output logic        mem_re,
  output logic        mem_we,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic        halted
);
  localparam int NREG = 16;

  typedef enum logic [3:0] {
    S_FETCH, S_DEC, S_LD, S_LDW, S_ST, S_STI, S_IMM, S_ADD, S_SUB, S_JZ, S_HALT
  } st_t;

  st_t st, st_nx;
  logic [15:0] pc, ir;
  logic [15:0] rf [NREG];

  logic [3:0] rn, rm;
  logic [7:0] fld;
  assign rn  = ir[11:8];
  assign rm  = ir[7:4];
  assign fld = ir[7:0];

  logic [1:0] msel, wsel;
  logic alu_sub, rf_we, pc_inc, pc_ld, ir_ld;
  logic [15:0] r1, r2, alu_b, alu_y, wd;
  logic alu_z;

  assign r1    = rf[rn];
  assign r2    = rf[rm];
  assign alu_b = (st == S_JZ) ? 16'd0 : r2;
  assign alu_y = alu_sub ? r1 - alu_b : r1 + alu_b;
  assign alu_z = (alu_y == 16'd0);

  always_comb begin
    msel = 2'd0; wsel = 2'd0; alu_sub = 1'b0;
    rf_we = 1'b0; pc_inc = 1'b0; pc_ld = 1'b0; ir_ld = 1'b0;
    mem_re = 1'b0; mem_we = 1'b0;
    st_nx = S_FETCH;
    case (st)
      S_FETCH: begin mem_re = 1'b1; pc_inc = 1'b1; st_nx = S_DEC; end
      S_DEC: begin
        ir_ld = 1'b1;
        case (mem_rdata[15:12])
          4'd0: st_nx = S_LD;
          4'd1: st_nx = S_ST;
          4'd2: st_nx = S_STI;
          4'd3: st_nx = S_IMM;
          4'd4: st_nx = S_ADD;
          4'd5: st_nx = S_SUB;
          4'd6: st_nx = S_JZ;
          default: st_nx = S_HALT;
        endcase
      end
      S_LD:  begin msel = 2'd1; mem_re = 1'b1; st_nx = S_LDW; end
      S_LDW: begin rf_we = 1'b1; wsel = 2'd1; end
      S_ST:  begin msel = 2'd1; mem_we = 1'b1; end
      S_STI: begin msel = 2'd2; mem_we = 1'b1; end
      S_IMM: begin rf_we = 1'b1; wsel = 2'd2; end
      S_ADD: rf_we = 1'b1;
      S_SUB: begin rf_we = 1'b1; alu_sub = 1'b1; end
      S_JZ:  pc_ld = alu_z;
      default: st_nx = S_HALT;
    endcase
  end

  always_comb begin
    case (msel)
      2'd1:    mem_addr = {8'd0, fld};
      2'd2:    mem_addr = r1;
      default: mem_addr = pc;
    endcase
    case (wsel)
      2'd1:    wd = mem_rdata;
      2'd2:    wd = {8'd0, fld};
      default: wd = alu_y;
    endcase
  end

  assign mem_wdata = (st == S_STI) ? r2 : r1;
  assign halted    = (st == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_FETCH;
      pc <= 16'd0;
      ir <= 16'd0;
    end else begin
      st <= st_nx;
      if (ir_ld) ir <= mem_rdata;
      if (pc_ld) pc <= pc + {{8{fld[7]}}, fld};
      else if (pc_inc) pc <= pc + 16'd1;
    end
  end

  always_ff @(posedge clk)
    if (!rst && rf_we) rf[rn] <= wd;

  // R2
  no_dual_access_chk: assert property (@(posedge clk) disable iff (rst) !(mem_re && mem_we));
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> (pc == $past(pc) + 16'd1));
  // R2
  dec_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC) |-> ($past(st) == S_FETCH));
  // R9
  jz_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_JZ && r1 != 16'd0) |=> (pc == $past(pc)));
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst) halted |=> halted);
  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst) halted |-> (!mem_re && !mem_we));
endmodule

// File: tb/tb_mc_proc.sv
module tb_mc_proc;
  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_re, mem_we, halted;

  always #2 clk = ~clk;

  mc_proc dut (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
               .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted));

  logic [15:0] mem [256];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
  end

  typedef struct { bit re; bit we; bit hlt; logic [15:0] a; logic [15:0] d; string tag; } cyc_t;
  cyc_t q[$];
  logic [15:0] mm [256];
  logic [15:0] r [16];
  int total = 0, bad = 0, cycles = 0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(bit re, bit we, logic [15:0] a, logic [15:0] d, bit h, string tag);
    cyc_t c;
    c.re = re; c.we = we; c.a = a; c.d = d; c.hlt = h; c.tag = tag;
    q.push_back(c);
  endtask

  task automatic model();
    logic [15:0] pc = 16'd0, ins;
    logic [3:0] n, m;
    logic [7:0] f;
    bit first = 1'b1;
    q.delete();
    for (int i = 0; i < 16; i++) r[i] = 16'hxxxx;
    for (int k = 0; k < 2000; k++) begin
      push(1, 0, pc, 16'd0, 0, first ? "R1" : "R2");
      first = 1'b0;
      ins = mm[pc[7:0]];
      pc = pc + 16'd1;
      push(0, 0, 16'd0, 16'd0, 0, "R2");
      n = ins[11:8]; m = ins[7:4]; f = ins[7:0];
      case (ins[15:12])
        4'd0: begin push(1, 0, {8'd0, f}, 16'd0, 0, "R3"); push(0, 0, 16'd0, 16'd0, 0, "R3"); r[n] = mm[f]; end
        4'd1: begin push(0, 1, {8'd0, f}, r[n], 0, "R4"); mm[f] = r[n]; end
        4'd2: begin push(0, 1, r[n], r[m], 0, "R5"); mm[r[n][7:0]] = r[m]; end
        4'd3: begin push(0, 0, 16'd0, 16'd0, 0, "R6"); r[n] = {8'd0, f}; end
        4'd4: begin push(0, 0, 16'd0, 16'd0, 0, "R7"); r[n] = r[n] + r[m]; end
        4'd5: begin push(0, 0, 16'd0, 16'd0, 0, "R7"); r[n] = r[n] - r[m]; end
        4'd6: begin
          push(0, 0, 16'd0, 16'd0, 0, (r[n] == 16'd0) ? "R8" : "R9");
          if (r[n] == 16'd0) pc = pc + {{8{f[7]}}, f};
        end
        default: begin
          for (int j = 0; j < 20; j++) push(0, 0, 16'd0, 16'd0, 1, "R10");
          return;
        end
      endcase
    end
  endtask

  task automatic run();
    rst = 1'b1;
    for (int i = 0; i < 256; i++) mm[i] = mem[i];
    model();
    repeat (3) @(negedge clk);
    chk("R1 halted in reset", {15'd0, halted}, 16'd0);
    chk("R1 write in reset", {15'd0, mem_we}, 16'd0);
    rst = 1'b0;
    foreach (q[i]) begin
      chk({q[i].tag, " halted"}, {15'd0, halted}, {15'd0, q[i].hlt});
      chk({q[i].tag, " read"}, {15'd0, mem_re}, {15'd0, q[i].re});
      chk({q[i].tag, " write"}, {15'd0, mem_we}, {15'd0, q[i].we});
      if (q[i].re || q[i].we) chk({q[i].tag, " addr"}, mem_addr, q[i].a);
      if (q[i].we) chk({q[i].tag, " wdata"}, mem_wdata, q[i].d);
      @(negedge clk);
    end
    rst = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h1234;
    mem[0] = 16'h3000; mem[1] = 16'h310A; mem[2] = 16'h3201; mem[3] = 16'h3300;
    mem[4] = 16'h6103; mem[5] = 16'h4010; mem[6] = 16'h5120; mem[7] = 16'h63FC;
    mem[8] = 16'h1080; mem[9] = 16'hF000;
    run();
    chk("R11 sum of 1..10", mem[8'h80], 16'd55);

    for (int i = 0; i < 256; i++) mem[i] = 16'h1234;
    mem[8'h90] = 16'hFFFF;
    mem[0]  = 16'h0490; mem[1]  = 16'h3502; mem[2]  = 16'h4450; mem[3]  = 16'h36A0;
    mem[4]  = 16'h2640; mem[5]  = 16'h3700; mem[6]  = 16'h5750; mem[7]  = 16'h1791;
    mem[8]  = 16'h38FF; mem[9]  = 16'h1892; mem[10] = 16'h6501; mem[11] = 16'h1593;
    mem[12] = 16'h3900; mem[13] = 16'h6901; mem[14] = 16'h1594; mem[15] = 16'h7000;
    run();
    chk("R5 indirect store of wrapped load+add (R3 R7)", mem[8'hA0], 16'h0001);
    chk("R7 subtract wraps", mem[8'h91], 16'hFFFE);
    chk("R6 immediate zero-extended", mem[8'h92], 16'h00FF);
    chk("R9 untaken branch falls through", mem[8'h93], 16'h0002);
    chk("R8 taken branch skips store", mem[8'h94], 16'h1234);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule